// File: doc/BRIEF.md
# Cycle-Stealing DMA Request Handshake

This block turns an asynchronous external transfer-request line into single DMA bus transfers. The request line is synchronised and watched for low-to-high transitions. Each transition that is accepted raises a request toward a simple bus arbiter. Once the arbiter grants, the block runs one transfer and hands the bus back to the CPU with a one-cycle release pulse. In dual-address mode a transfer is a read cycle followed by a write cycle. In single-address mode it is one cycle.

An active-high acknowledge strobe marks the DMA bus cycle that belongs to the external device. In single-address mode that is the only cycle. In dual-address mode a configuration bit places it in either the read or the write cycle. The transfer width code is captured together with the other settings and passed to the bus side unchanged. From acceptance until a configurable number of cycles after the release, the block is blind: request transitions seen in that window are discarded, not queued. An enable input withdraws pending requests and holds the acknowledge low.

Top module: `dreq_steal_handshake`

## Requirements
- R1: `dreq` passes through a SYNC_STAGES-flop synchroniser (default 2) and is then compared with a one-cycle-delayed copy. If `dreq` is first high at clock edge k while the block is idle and enabled, `bus_req` is 0 after edge k+1 and 1 after edge k+2.
- R2: Only a low-to-high transition is a request. Holding `dreq` high produces no further request after the first.
- R3: `bus_req` stays high until an edge that samples `bus_gnt`=1. The transfer then starts on the next cycle. With `cfg_single`=1 this is one `bus_cyc` cycle with `bus_wr_ph`=0. With `cfg_single`=0 this is a read cycle (`bus_cyc`=1, `bus_wr_ph`=0) followed by a write cycle (`bus_cyc`=1, `bus_wr_ph`=1).
- R4: The cycle after the last transfer cycle, `bus_rel` is 1 for exactly one cycle and `bus_req` is 0. `bus_req` then stays 0 through that cycle and the GAP_CYC cycles (default 2) that follow.
- R5: From the acceptance edge until the GAP_CYC cycles after the release have passed, request transitions are dropped. A new acceptance is only possible after that.
- R6: `dack` is active high and is asserted for exactly one cycle per completed transfer. It falls in the single cycle when `cfg_single`=1. When `cfg_single`=0 it falls in the read cycle if `cfg_ack_wr`=0 and in the write cycle if `cfg_ack_wr`=1.
- R7: `xfer_width` equals the `cfg_width` code sampled on the acceptance edge (00 byte, 01 word, 10 longword; other codes pass unchanged). It holds that value while `bus_req` is high.
- R8: `cfg_single` and `cfg_ack_wr` are sampled on the acceptance edge. Changing them later has no effect on the transfer in progress.
- R9: While `en`=0 no request is accepted and `dack` is 0. `en`=0 in the request-wait state returns the block to idle (`bus_req` low after the next edge), even when `bus_gnt` is 1 in that cycle. `en`=0 in a read cycle goes straight to the release cycle.
- R10: A synchronous active-high `rst` clears the synchroniser, returns the block to idle and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables acceptance; low withdraws requests and forces dack low |
| dreq | input | 1 | Asynchronous transfer request, rising-edge sensitive |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cfg_ack_wr | input | 1 | Dual mode: 0 = acknowledge in read cycle, 1 = in write cycle |
| cfg_single | input | 1 | 1 = single-address transfer, 0 = dual-address |
| cfg_width | input | 2 | Transfer width code |
| bus_req | output | 1 | Bus request toward the arbiter, held through the transfer |
| bus_cyc | output | 1 | A DMA bus cycle is in progress |
| bus_wr_ph | output | 1 | The current DMA cycle is the write cycle of a dual transfer |
| bus_rel | output | 1 | One-cycle pulse handing the bus back to the CPU |
| dack | output | 1 | Active-high acknowledge strobe to the requesting device |
| xfer_width | output | 2 | Captured transfer width code |

## Verification
Two events can coincide. The enable can drop in the same cycle as a grant, and a request transition can reach the edge detector in the last blind cycle or in the first open cycle. Random toggling of `dreq`, `en` and `bus_gnt` against a cycle-stepped reference model produces both collisions many times. In each case the enable must win over the grant, and a transition seen one cycle too early must vanish without a trace. Directed sequences pin the acceptance latency, held-high requests, configuration changes in mid-transfer and enable withdrawal.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

   localparam int WIDTH_CODE_BITS = 2;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_RD   = 3'd2,
      ST_WR   = 3'd3,
      ST_SGL  = 3'd4,
      ST_REL  = 3'd5,
      ST_GAP  = 3'd6
   } dmah_state_e;

   typedef struct packed {
      logic                       ack_wr;
      logic                       single;
      logic [WIDTH_CODE_BITS-1:0] width;
   } dmah_cfg_t;

endpackage

// File: rtl/dmah_reqsync.sv
module dmah_reqsync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   dly_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("dmah_reqsync: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= 1'b0;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) dly_q <= 1'b0;
      else     dly_q <= chain_q[LAST];
   end

   assign rise = chain_q[LAST] & ~dly_q;

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise); // R2

endmodule

// File: rtl/dmah_gap_timer.sv
module dmah_gap_timer #(
   parameter int GAP_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic last
);
   localparam int CW = $clog2(GAP_CYC + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYC);
   localparam logic [CW-1:0] ONE      = CW'(1);

   logic [CW-1:0] cnt_q;

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("dmah_gap_timer: GAP_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (load)           cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
   end

   assign last = (cnt_q == ONE);

   AST_GAP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '0 && !load) |=> cnt_q == '0); // R5
   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LOAD_VAL); // R4

endmodule

// File: rtl/dmah_seq.sv
module dmah_seq
   import dmah_pkg::*;
(
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       en,
   input  logic                       rise,
   input  logic                       gnt,
   input  dmah_cfg_t                  cfg_in,
   input  logic                       gap_last,
   output logic                       gap_load,
   output logic                       bus_req,
   output logic                       bus_cyc,
   output logic                       bus_wr_ph,
   output logic                       bus_rel,
   output logic                       dack,
   output logic [WIDTH_CODE_BITS-1:0] xfer_width
);
   dmah_state_e state_q, state_d;
   dmah_cfg_t   cfg_q;
   logic        accept;

   assign accept = (state_q == ST_IDLE) && en && rise;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept) state_d = ST_REQ;
         ST_REQ: begin
            if (!en)      state_d = ST_IDLE;
            else if (gnt) state_d = cfg_q.single ? ST_SGL : ST_RD;
         end
         ST_RD:   state_d = en ? ST_WR : ST_REL;
         ST_WR:   state_d = ST_REL;
         ST_SGL:  state_d = ST_REL;
         ST_REL:  state_d = ST_GAP;
         ST_GAP:  if (gap_last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) cfg_q <= cfg_in;
      end
   end

   always_comb begin
      bus_req   = 1'b0;
      bus_cyc   = 1'b0;
      bus_wr_ph = 1'b0;
      bus_rel   = 1'b0;
      dack      = 1'b0;
      unique case (state_q)
         ST_REQ: bus_req = 1'b1;
         ST_RD: begin
            bus_req = 1'b1;
            bus_cyc = 1'b1;
            dack    = en & ~cfg_q.ack_wr;
         end
         ST_WR: begin
            bus_req   = 1'b1;
            bus_cyc   = 1'b1;
            bus_wr_ph = 1'b1;
            dack      = en & cfg_q.ack_wr;
         end
         ST_SGL: begin
            bus_req = 1'b1;
            bus_cyc = 1'b1;
            dack    = en;
         end
         ST_REL:  bus_rel = 1'b1;
         default: ;
      endcase
   end

   assign gap_load   = (state_q == ST_REL);
   assign xfer_width = cfg_q.width;

   AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (bus_req && $past(bus_req)) |-> $stable(xfer_width)); // R7
   AST_CYC_TO_REL: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WR || state_q == ST_SGL) |=> bus_rel); // R4
   AST_REL_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
      bus_rel |=> !bus_req); // R4
   AST_ACK_INSIDE_CYC: assert property (@(posedge clk) disable iff (rst)
      dack |-> bus_cyc); // R6
   AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
      (dack && bus_wr_ph) |-> !$past(dack)); // R6
   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_req) |-> $past(state_q) == ST_IDLE); // R5
   AST_EN_DROP: assert property (@(posedge clk) disable iff (rst)
      (!en && state_q == ST_REQ) |=> !bus_req); // R9

endmodule

// File: rtl/dreq_steal_handshake.sv
module dreq_steal_handshake
   import dmah_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYC     = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic       dreq,
   input  logic       bus_gnt,
   input  logic       cfg_ack_wr,
   input  logic       cfg_single,
   input  logic [1:0] cfg_width,
   output logic       bus_req,
   output logic       bus_cyc,
   output logic       bus_wr_ph,
   output logic       bus_rel,
   output logic       dack,
   output logic [1:0] xfer_width
);
   logic      rise;
   logic      gap_load;
   logic      gap_last;
   dmah_cfg_t cfg_bus;

   assign cfg_bus = '{ack_wr: cfg_ack_wr, single: cfg_single, width: cfg_width};

   dmah_reqsync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (dreq),
      .rise (rise)
   );

   dmah_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
      .clk  (clk),
      .rst  (rst),
      .load (gap_load),
      .last (gap_last)
   );

   dmah_seq i_seq (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .rise       (rise),
      .gnt        (bus_gnt),
      .cfg_in     (cfg_bus),
      .gap_last   (gap_last),
      .gap_load   (gap_load),
      .bus_req    (bus_req),
      .bus_cyc    (bus_cyc),
      .bus_wr_ph  (bus_wr_ph),
      .bus_rel    (bus_rel),
      .dack       (dack),
      .xfer_width (xfer_width)
   );

endmodule

// File: tb/test_dreq_steal_handshake.sv
`timescale 1ns/1ps
module test_dreq_steal_handshake;
   localparam int GAP = 2;
   localparam int M_IDLE = 0, M_REQ = 1, M_RD = 2, M_WR = 3, M_SGL = 4, M_REL = 5, M_GAP = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0, dreq = 1'b0, bus_gnt = 1'b0;
   logic cfg_ack_wr = 1'b0, cfg_single = 1'b0;
   logic [1:0] cfg_width = 2'b00;
   logic bus_req, bus_cyc, bus_wr_ph, bus_rel, dack;
   logic [1:0] xfer_width;

   int total = 0, bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dreq_steal_handshake i_dreq_steal_handshake (
      .clk(clk), .rst(rst), .en(en), .dreq(dreq), .bus_gnt(bus_gnt),
      .cfg_ack_wr(cfg_ack_wr), .cfg_single(cfg_single), .cfg_width(cfg_width),
      .bus_req(bus_req), .bus_cyc(bus_cyc), .bus_wr_ph(bus_wr_ph),
      .bus_rel(bus_rel), .dack(dack), .xfer_width(xfer_width)
   );

   task automatic check(input string req, input string what, input int act, input int exp_v);
      total++;
      if (act != exp_v) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
      end
   endtask

   // reference model, stepped on each rising edge
   int m_st = M_IDLE, m_left = 0;
   bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_ackwr = 0, m_sgl = 0;
   int m_wd = 0;

   always @(posedge clk) begin
      bit rise_m;
      if (rst) begin
         m_st = M_IDLE; m_left = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
         m_ackwr = 0; m_sgl = 0; m_wd = 0;
      end else begin
         rise_m = m_s2 && !m_s3;
         case (m_st)
            M_IDLE: if (en && rise_m) begin
               m_st = M_REQ; m_wd = int'(cfg_width); m_ackwr = cfg_ack_wr; m_sgl = cfg_single;
            end
            M_REQ: begin
               if (!en) m_st = M_IDLE;
               else if (bus_gnt) m_st = m_sgl ? M_SGL : M_RD;
            end
            M_RD: m_st = en ? M_WR : M_REL;
            M_WR, M_SGL: m_st = M_REL;
            M_REL: begin m_st = M_GAP; m_left = GAP; end
            default: begin
               if (m_left == 1) m_st = M_IDLE;
               m_left--;
            end
         endcase
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = dreq;
      end
   end

   function automatic int exp_req(int st);
      return (st == M_REQ || st == M_RD || st == M_WR || st == M_SGL) ? 1 : 0;
   endfunction
   function automatic int exp_cyc(int st);
      return (st == M_RD || st == M_WR || st == M_SGL) ? 1 : 0;
   endfunction
   function automatic int exp_dack(int st, bit e, bit aw);
      return (e && (st == M_SGL || (st == M_RD && !aw) || (st == M_WR && aw))) ? 1 : 0;
   endfunction

   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         check("R3", "bus_req", int'(bus_req), exp_req(m_st));
         check("R3", "bus_cyc", int'(bus_cyc), exp_cyc(m_st));
         check("R3", "bus_wr_ph", int'(bus_wr_ph), (m_st == M_WR) ? 1 : 0);
         check("R4", "bus_rel", int'(bus_rel), (m_st == M_REL) ? 1 : 0);
         check("R6", "dack", int'(dack), exp_dack(m_st, en, m_ackwr));
         check("R7", "xfer_width", int'(xfer_width), m_wd);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed, ncyc, nack, nackwr, nrel, nreq;
      seed = 32'h5EED;
      void'($urandom(seed));

      // R10: reset state
      step(4);
      check("R10", "bus_req in reset", int'(bus_req), 0);
      check("R10", "outputs in reset", int'({bus_cyc, bus_wr_ph, bus_rel, dack}), 0);
      check("R10", "xfer_width in reset", int'(xfer_width), 0);
      rst = 1'b0;
      cmp_on = 1'b1;
      en = 1'b1; bus_gnt = 1'b1; cfg_single = 1'b1; cfg_width = 2'b10;
      step(2);

      // R1: latency of acceptance
      dreq = 1'b1;
      step(2);
      check("R1", "bus_req after 2 edges", int'(bus_req), 0);
      step(1);
      check("R1", "bus_req after 3 edges", int'(bus_req), 1);
      check("R7", "width captured", int'(xfer_width), 2);
      step(1);
      check("R3", "single cycle", int'(bus_cyc), 1);
      check("R6", "dack in single cycle", int'(dack), 1);
      step(1);
      check("R4", "release pulse", int'(bus_rel), 1);
      check("R4", "bus_req low at release", int'(bus_req), 0);
      // R2: held high gives nothing more
      nreq = 0;
      for (int i = 0; i < 12; i++) begin step(1); nreq += int'(bus_req); end
      check("R2", "no request while dreq held", nreq, 0);

      // R5: second edge inside blind window is dropped
      dreq = 1'b0; step(3);
      dreq = 1'b1; step(1);
      dreq = 1'b0; step(2);
      dreq = 1'b1;
      nrel = 0;
      for (int i = 0; i < 20; i++) begin step(1); nrel += int'(bus_rel); end
      check("R5", "one transfer for two close edges", nrel, 1);

      // R9: disabled block ignores requests
      en = 1'b0; dreq = 1'b0; step(3);
      dreq = 1'b1;
      nreq = 0;
      for (int i = 0; i < 6; i++) begin step(1); nreq += int'(bus_req); end
      check("R9", "no accept while disabled", nreq, 0);
      en = 1'b1; bus_gnt = 1'b0; dreq = 1'b0; step(3);
      dreq = 1'b1; step(3);
      check("R3", "request waits for grant", int'(bus_req), 1);
      step(2);
      check("R3", "still waiting", int'(bus_req), 1);
      en = 1'b0; bus_gnt = 1'b1; step(1);
      check("R9", "enable drop withdraws request", int'(bus_req), 0);
      en = 1'b1; bus_gnt = 1'b0; dreq = 1'b0; step(3);

      // R8: config changes after acceptance are ignored
      cfg_single = 1'b0; cfg_ack_wr = 1'b1; cfg_width = 2'b01;
      dreq = 1'b1; step(3);
      check("R8", "accepted", int'(bus_req), 1);
      cfg_single = 1'b1; cfg_ack_wr = 1'b0; cfg_width = 2'b11;
      step(1);
      bus_gnt = 1'b1;
      ncyc = 0; nack = 0; nackwr = 0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         ncyc += int'(bus_cyc); nack += int'(dack); nackwr += int'(dack && bus_wr_ph);
      end
      check("R8", "dual transfer kept two cycles", ncyc, 2);
      check("R8", "ack kept in write cycle", nackwr, 1);
      check("R6", "one ack per transfer", nack, 1);
      check("R7", "width kept", int'(xfer_width), 1);

      // random phase against model (covers R5/R9 collisions)
      dreq = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         step(1);
         if ($urandom_range(0, 99) < 30) dreq = ~dreq;
         en = ($urandom_range(0, 99) < 90);
         bus_gnt = ($urandom_range(0, 99) < 60);
         cfg_single = $urandom_range(0, 1) == 1;
         cfg_ack_wr = $urandom_range(0, 1) == 1;
         cfg_width = 2'($urandom_range(0, 3));
      end
      step(1);

      // R10: reset mid-operation
      rst = 1'b1; step(1);
      check("R10", "reset clears outputs", int'({bus_req, bus_cyc, bus_rel, dack}), 0);
      cmp_on = 1'b0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule